// File: doc/BRIEF.md
# Keyed Watchdog Timer with Power-Down Hold-Off

This block is a watchdog counter clocked by the watchdog clock. Software arms it, and later keeps it alive, by writing two key bytes in a row to a write-only register port. The first byte is 0x1E and the second is 0xE1. If a service does not arrive in time, the counter overflows. The block then drives its reset output high for a fixed number of cycles, clears the count and starts counting again. A 3-bit select input picks one of eight timeout lengths, and each code doubles the one below it.

Two power-state inputs are provided. Idle has no effect on the watchdog: it keeps counting and can still fire. Power-down stops the watchdog clock, so every piece of state freezes and writes are lost. When power-down ends while the active-low wake interrupt line is still low, counting is held off until that line goes high. Key writes are still accepted during the hold-off. The system reset asynchronously clears the block, and its release is synchronised inside the block.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, the count is zero and `wdt_rst_o` is low, and it stays low for any length of time until a valid key pair is written.
- R2: A write of 0x1E followed by a write of 0xE1 as the very next write arms the watchdog. Cycles without a write between the two bytes are allowed.
- R3: Writing the key pair while the watchdog is armed restarts the count from zero, so regular servicing prevents any reset pulse.
- R4: Any write other than 0xE1 directly after 0x1E cancels the pair. A lone 0xE1 does nothing. A 0x1E write always starts a new pair, so 0x1E, 0x1E, 0xE1 is a valid pair.
- R5: With select value S (0 to 7), the reset pulse begins BASE_MULT·2^(BASE_SHIFT+S) counted cycles after the service or arming write. The defaults are 6 and 14, which gives 98,304 cycles for S=0.
- R6: On overflow `wdt_rst_o` is high for exactly RST_CYCLES cycles while the count stays at zero. Counting then resumes from zero, and the next timeout needs a full period again.
- R7: Once armed, no write of any value disarms the watchdog. Only the system reset disarms it.
- R8: While `pdown_i` is high, the count, the pulse timer, the key detector and the armed state all hold their values, and writes are ignored.
- R9: `idle_i` has no effect on counting or on the timeout.
- R10: If `pdown_i` falls while `wake_irq_n` is low, counting stays stopped until `wake_irq_n` goes high. If `pdown_i` falls while the line is high, counting resumes at once.
- R11: A system reset during operation disarms the watchdog and clears any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe for the key register |
| wr_data | input | 8 | Write data byte |
| tsel | input | 3 | Timeout select code S |
| idle_i | input | 1 | Core is in idle mode |
| pdown_i | input | 1 | Core is in power-down; the watchdog clock is stopped |
| wake_irq_n | input | 1 | Level-sensitive wake interrupt, active low |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
Several write streams are applied. A lone second byte and a pair broken by a foreign byte show whether the detector demands strict adjacency. A doubled first byte shows whether that byte restarts detection. Periodic servicing against an unserviced run separates restart from arming, and a sweep over all eight select codes checks that each period doubles. Power-down entered mid-count and mid-pulse, with exits taken under both wake-line levels, tells a true freeze apart from a reset of the state, and tells the hold-off apart from an immediate resume.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  typedef enum logic {
    KS_WAIT  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       svc_o,
  output logic       armed_o
);

  key_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       svc;

  always_comb begin
    state_d = state_q;
    svc     = 1'b0;
    if (tick_i && wr_en_i) begin
      if (wr_data_i == KEY_FIRST) begin
        state_d = KS_ARMED;
      end else begin
        state_d = KS_WAIT;
        if (state_q == KS_ARMED && wr_data_i == KEY_SECOND) begin
          svc = 1'b1;
        end
      end
    end
    armed_d = armed_q | svc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_WAIT;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign svc_o   = svc;
  assign armed_o = armed_q;

  AST_FIRST_KEY_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && wr_en_i && wr_data_i == KEY_FIRST) |=> (state_q == KS_ARMED)); // R4
  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R7
  AST_NO_ARM_IN_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !armed_q) |=> !armed_q); // R8

endmodule

// File: rtl/wdk_gate.sv
module wdk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pdown_i,
  input  logic idle_i,
  input  logic wake_n_i,
  output logic tick_o,
  output logic run_o
);

  logic pd_q;
  logic hold_q, hold_d;
  logic pd_exit;

  always_comb begin
    pd_exit = pd_q & ~pdown_i;
    hold_d  = (hold_q | pd_exit) & ~wake_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pd_q   <= pdown_i;
      hold_q <= hold_d;
    end
  end

  assign tick_o = ~pdown_i;
  assign run_o  = ~pdown_i & ~hold_d;

  AST_HOLD_NEEDS_LOW_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> $past(!wake_n_i)); // R10
  AST_HOLD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && wake_n_i && !pdown_i) |-> run_o); // R10
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !pdown_i && !hold_q && wake_n_i) |-> run_o); // R9

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int BASE_MULT  = 6,
  parameter int BASE_SHIFT = 14,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             run_i,
  input  logic             svc_i,
  input  logic             busy_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);

  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = $clog2(BASE_MULT + 1) + BASE_SHIFT + NSEL - 1;

  logic [CNT_W-1:0] lim_tab [NSEL];
  logic [CNT_W-1:0] lim_m1;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;
  logic             at_end;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(BASE_MULT) << (BASE_SHIFT + g);
  end

  always_comb begin
    lim_m1 = lim_tab[sel_i] - CNT_W'(1);
    step   = armed_i & run_i & ~busy_i & ~svc_i;
    at_end = (cnt_q >= lim_m1);
    cnt_d  = cnt_q;
    if (svc_i) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (svc_i || step) begin
      cnt_q <= cnt_d;
    end
  end

  assign ovf_o = step & at_end;

  AST_ZERO_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |-> (cnt_q == '0)); // R1
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !svc_i) |=> $stable(cnt_q)); // R8
  AST_ZERO_DURING_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (cnt_q == '0)); // R6

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o
);

  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] pls_q, pls_d;

  always_comb begin
    pls_d = pls_q;
    if (start_i) begin
      pls_d = PW'(RST_CYCLES);
    end else if (pls_q != '0) begin
      pls_d = pls_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= '0;
    end else if (tick_i) begin
      pls_q <= pls_d;
    end
  end

  assign busy_o = (pls_q != '0);

  AST_PULSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pls_q)); // R8
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (pls_q == '0)); // R6

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int BASE_MULT  = 6,
  parameter int BASE_SHIFT = 14,
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [2:0] tsel,
  input  logic       idle_i,
  input  logic       pdown_i,
  input  logic       wake_irq_n,
  output logic       wdt_rst_o
);

  localparam int SEL_W = 3;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       tick, run, svc, armed, ovf, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  wdk_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pdown_i  (pdown_i),
    .idle_i   (idle_i),
    .wake_n_i (wake_irq_n),
    .tick_o   (tick),
    .run_o    (run)
  );

  wdk_keyseq u_keys (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .svc_o     (svc),
    .armed_o   (armed)
  );

  wdk_counter #(
    .BASE_MULT  (BASE_MULT),
    .BASE_SHIFT (BASE_SHIFT),
    .SEL_W      (SEL_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .armed_i (armed),
    .run_i   (run),
    .svc_i   (svc),
    .busy_i  (busy),
    .sel_i   (tsel),
    .ovf_o   (ovf)
  );

  wdk_pulse #(
    .RST_CYCLES (RST_CYCLES)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick_i  (tick),
    .start_i (ovf),
    .busy_o  (busy)
  );

  assign wdt_rst_o = busy;

  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n_int)
    wdt_rst_o |-> armed); // R1

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  localparam int MULT = 6;
  localparam int SHIFT = 2;
  localparam int RSTC = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [2:0] tsel;
  logic       idle_i, pdown_i, wake_irq_n;
  logic       wdt_rst_o;

  int    errs = 0;
  int    checks = 0;
  int    pulses = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";
  logic  prev_rst = 1'b0;

  int m_rs, m_en, m_cnt, m_pulse, m_flag, m_hold, m_pdp;

  always #10 clk = ~clk;

  keyed_watchdog #(.BASE_MULT(MULT), .BASE_SHIFT(SHIFT), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tsel(tsel),
    .idle_i(idle_i), .pdown_i(pdown_i), .wake_irq_n(wake_irq_n), .wdt_rst_o(wdt_rst_o)
  );

  // Behavioural reference model, one update per clock.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_en = 0; m_cnt = 0; m_pulse = 0; m_flag = 0; m_hold = 0; m_pdp = 0;
    end else if (m_rs < 2) begin
      m_rs = m_rs + 1;
    end else begin
      int  lim;
      bit  svc;
      bit  exitp;
      int  busy_before;
      exitp  = (m_pdp != 0) && !pdown_i;
      m_hold = ((m_hold != 0) || exitp) && !wake_irq_n;
      m_pdp  = pdown_i;
      if (!pdown_i) begin
        svc = 0;
        busy_before = m_pulse;
        if (wr_en) begin
          if (wr_data == 8'h1E) m_flag = 1;
          else begin
            if (wr_data == 8'hE1 && m_flag != 0) svc = 1;
            m_flag = 0;
          end
        end
        if (svc) m_en = 1;
        if (m_pulse > 0) m_pulse = m_pulse - 1;
        lim = MULT << (SHIFT + tsel);
        if (svc) m_cnt = 0;
        else if (m_en != 0 && busy_before == 0 && m_hold == 0) begin
          if (m_cnt >= lim - 1) begin
            m_cnt = 0;
            m_pulse = RSTC;
          end else m_cnt = m_cnt + 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) chk(cur_req, wdt_rst_o, (m_pulse > 0) ? 1 : 0);
    if (wdt_rst_o && !prev_rst) pulses++;
    prev_rst = wdt_rst_o;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic key_pair();
    wr(8'h1E);
    tick(2);
    wr(8'hE1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    chk("R11 reset output low", wdt_rst_o, 0);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; tsel = 3'd0;
    idle_i = 1'b0; pdown_i = 1'b0; wake_irq_n = 1'b1;
    tick(4);
    chk("R1 reset state", wdt_rst_o, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    tick(150);
    chk("R1 no pulse while disarmed", pulses, 0);

    cur_req = "R4";
    wr(8'hE1); tick(60);
    wr(8'h1E); wr(8'h55); wr(8'hE1); tick(60);
    wr(8'h1E); wr(8'h00); wr(8'hE1); tick(60);
    chk("R4 broken pairs do not arm", pulses, 0);

    cur_req = "R2";
    wr(8'h1E); tick(5); wr(8'hE1);
    tick(24 + RSTC + 24 + RSTC + 6);
    chk("R2 R6 two timeouts after arming", pulses, 2);

    cur_req = "R3";
    pulses = 0;
    key_pair();
    for (int i = 0; i < 10; i++) begin
      tick(10);
      key_pair();
    end
    wr(8'h1E); wr(8'h1E); wr(8'hE1);
    tick(15);
    chk("R3 R4 serviced watchdog stays quiet", pulses, 0);

    cur_req = "R5";
    for (int s = 0; s < 8; s++) begin
      tsel = 3'(s);
      pulses = 0;
      key_pair();
      tick((MULT << (SHIFT + s)) + RSTC + 4);
      chk("R5 one pulse per period", pulses, 1);
    end
    tsel = 3'd0;

    cur_req = "R7";
    pulses = 0;
    key_pair();
    wr(8'h00); wr(8'hFF); wr(8'hE1); wr(8'h1E); wr(8'hA5);
    tick(80);
    chk("R7 still armed after junk writes", pulses > 0 ? 1 : 0, 1);

    cur_req = "R9";
    key_pair();
    idle_i = 1'b1;
    tick(70);
    idle_i = 1'b0;

    cur_req = "R8";
    key_pair();
    tick(10);
    pdown_i = 1'b1;
    pulses = 0;
    tick(100);
    chk("R8 no pulse in power-down", pulses, 0);
    pdown_i = 1'b0;
    tick(40);
    begin
      int guard = 0;
      while (!wdt_rst_o && guard < 200) begin tick(1); guard++; end
    end
    tick(1);
    pdown_i = 1'b1;
    tick(20);
    chk("R8 pulse held in power-down", wdt_rst_o, 1);
    pdown_i = 1'b0;
    tick(30);

    cur_req = "R10";
    key_pair();
    tick(5);
    pdown_i = 1'b1;
    tick(20);
    pdown_i = 1'b0; wake_irq_n = 1'b0;
    pulses = 0;
    tick(80);
    chk("R10 hold-off while wake low", pulses, 0);
    wake_irq_n = 1'b1;
    tick(40);
    chk("R10 resumes after wake high", pulses > 0 ? 1 : 0, 1);
    key_pair();
    tick(5);
    pdown_i = 1'b1;
    tick(10);
    pdown_i = 1'b0;
    tick(40);

    cur_req = "R11";
    key_pair();
    tick(10);
    do_reset();
    pulses = 0;
    tick(120);
    chk("R11 disarmed after reset", pulses, 0);

    cur_req = "R8";
    pdown_i = 1'b1;
    key_pair();
    pdown_i = 1'b0;
    tick(100);
    chk("R8 writes in power-down ignored", pulses, 0);

    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule